// File: doc/BRIEF.md
# Four-Channel Shared-Counter Pulse-Width Modulator

This block drives four pulse-width outputs from a single 10-bit counter. The counter steps forward only when the tick-enable input is high, so an external prescaler sets the rate, and it wraps from 1023 back to 0. One pass through all 1024 counts is one PWM period, and the period is the same for every channel.

Each channel holds a 10-bit width value `n`. Its output is high while the counter is at or below `n`, which gives `n + 1` high counts per period. The duty cycle therefore runs from one count in 1024 up to a constant high level. There is no setting for zero duty.

Software writes a width through a one-cycle write strobe that carries a channel number and a data value. The value goes into a shadow register first. It becomes active only when the counter wraps, so a period never runs with a width that changed partway through it.

Top module: `pwm4_shared`

## Requirements
- R1: The shared counter starts at 0, goes up by one on each cycle with `tick_i` high, and goes from 1023 back to 0. One PWM period is exactly 1024 ticks.
- R2: A channel whose active width is `n` is high for exactly `n + 1` of the 1024 counts in a period.
- R3: The high time comes first in the period. The output is high for counter values 0 through `n` and low for values `n + 1` through 1023.
- R4: A width of 1023 (0x3FF) holds the output high through the whole period.
- R5: In a cycle with `tick_i` low, the counter keeps its value and every output keeps its level, even when a write takes place.
- R6: A write changes only the channel's shadow value. The output keeps following the old width until the counter wraps from 1023 to 0. The new width then applies from count 0.
- R7: A write that falls in the same cycle as the wrap (a tick while the counter is 1023) takes effect for the period that starts at that wrap.
- R8: `wr_sel_i` is a binary channel number: 0 selects `pwm_o[0]` and 3 selects `pwm_o[3]`. A write changes no channel other than the selected one.
- R9: After reset, the counter and all widths are 0. Every output is then high at count 0 and low for the other 1023 counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter advance enable from the external prescaler |
| wr_en_i | input | 1 | Width write strobe |
| wr_sel_i | input | 2 | Channel number for the write |
| wr_data_i | input | 10 | New width value `n` |
| pwm_o | output | 4 | PWM outputs, one bit per channel |

## Verification
Two events can happen in the same cycle: a width write and the counter wrap that copies shadow values into the active registers. The bench brings the counter to 1023 and then issues a tick and a write to channel 2 together. It checks that channel 2 uses the new width in the period that follows: high at count 7 and low at count 8. A second test writes in the middle of a period and checks that the old width stays in force until the next wrap.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int unsigned DEF_NUM_CH = 4;
  localparam int unsigned DEF_CNT_W  = 10;
endpackage

// File: rtl/pwm_tick_cnt.sv
module pwm_tick_cnt #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (cnt_q == CNT_MAX);
endmodule

// File: rtl/pwm_wr_decode.sv
module pwm_wr_decode #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  output logic [NUM_CH-1:0] hit_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign hit_o[g] = wr_en_i && (wr_sel_i == SEL_W'(g));
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_hit_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] active_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shadow_q <= '0;
    else if (wr_hit_i) shadow_q <= wr_data_i;
  end

  // a write in the wrap cycle is forwarded straight into the active width
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= '0;
    else if (wrap_i) active_q <= wr_hit_i ? wr_data_i : shadow_q;
  end

  assign active_o = active_q;
  assign pwm_o    = (cnt_i <= active_q);
endmodule

// File: rtl/pwm4_shared.sv
module pwm4_shared
  import pwm4_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [CNT_W-1:0]        cnt_q;
  logic                    wrap;
  logic [NUM_CH-1:0]       wr_hit;
  logic [NUM_CH*CNT_W-1:0] active_flat;

  pwm_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  pwm_wr_decode #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_dec (
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .hit_o    (wr_hit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_hit_i  (wr_hit[g]),
      .wr_data_i (wr_data_i),
      .wrap_i    (wrap),
      .cnt_i     (cnt_q),
      .active_o  (active_flat[g*CNT_W +: CNT_W]),
      .pwm_o     (pwm_o[g])
    );
  end
endmodule

// File: rtl/pwm4_shared_chk.sv
module pwm4_shared_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tick_i,
  input logic [CNT_W-1:0]        cnt_i,
  input logic [NUM_CH*CNT_W-1:0] active_i,
  input logic [NUM_CH-1:0]       pwm_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == CNT_MAX) |=> (cnt_i == '0));

  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i != CNT_MAX) |=> (cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(cnt_i) && $stable(pwm_o)));

  a_r3_first_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> (&pwm_o));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r4_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i[g*CNT_W +: CNT_W] == CNT_MAX) |-> pwm_o[g]);

    a_r6_load_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(tick_i && cnt_i == CNT_MAX) |=> $stable(active_i[g*CNT_W +: CNT_W]));
  end
endmodule

bind pwm4_shared pwm4_shared_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .cnt_i    (cnt_q),
  .active_i (active_flat),
  .pwm_o    (pwm_o)
);

// File: tb/pwm4_shared_tb_top.sv
`timescale 1ns/1ps
module pwm4_shared_tb_top;
  localparam int NV = 6;
  localparam int TV_SEL [NV] = '{0, 1, 2, 3, 0, 1};
  localparam int TV_W   [NV] = '{0, 1023, 511, 5, 1022, 1};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [9:0] wr_data_i = '0;
  logic [3:0] pwm_o;

  int checks = 0;
  int errors = 0;
  int tb_cnt = 0;
  int wexp [4] = '{0, 0, 0, 0};

  always #4 clk_i = ~clk_i;

  pwm4_shared dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .pwm_o(pwm_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit tk, input bit we, input int sel, input int data);
    @(negedge clk_i);
    tick_i = tk; wr_en_i = we; wr_sel_i = 2'(sel); wr_data_i = 10'(data);
    @(posedge clk_i);
    #2;
    tick_i = 1'b0; wr_en_i = 1'b0;
    if (tk) tb_cnt = (tb_cnt + 1) % 1024;
  endtask

  task automatic run_to(input int target);
    while (tb_cnt != target) step(1, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h, mism, rises, first_rise, gap;
    bit prev;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R9: all widths 0, counter 0
    chk(pwm_o == 4'hF, "R9 reset outputs", pwm_o, 15);
    step(1, 0, 0, 0);
    chk(pwm_o == 4'h0, "R9 low after first count", pwm_o, 0);

    // table walk: R2 count, R3 placement, R6 shadow hold
    for (int v = 0; v < NV; v++) begin
      run_to(100);
      step(0, 1, TV_SEL[v], TV_W[v]);
      chk(pwm_o[TV_SEL[v]] == (100 <= wexp[TV_SEL[v]]), "R6 old width kept",
          pwm_o[TV_SEL[v]], int'(100 <= wexp[TV_SEL[v]]));
      run_to(0);
      h = 0; mism = 0;
      for (int k = 0; k < 1024; k++) begin
        h += pwm_o[TV_SEL[v]];
        if (pwm_o[TV_SEL[v]] != (k <= TV_W[v])) mism++;
        if (k < 1023) step(1, 0, 0, 0);
      end
      wexp[TV_SEL[v]] = TV_W[v];
      chk(h == TV_W[v] + 1, "R2 high count", h, TV_W[v] + 1);
      chk(mism == 0, "R3 high at start of period", mism, 0);
      if (TV_W[v] == 1023) chk(h == 1024, "R4 full duty", h, 1024);
    end

    // R5: no tick, outputs frozen even with a write
    run_to(3);
    prev = pwm_o[3];
    mism = 0;
    for (int k = 0; k < 40; k++) begin
      step(0, (k == 10), 3, 0);
      if (pwm_o[3] != prev) mism++;
    end
    chk(mism == 0, "R5 outputs hold without tick", mism, 0);
    step(0, 1, 3, 5);  // restore channel 3 shadow

    // R7: write in the wrap cycle
    run_to(1023);
    step(1, 1, 2, 7);
    wexp[2] = 7;
    run_to(7);
    chk(pwm_o[2] == 1'b1, "R7 new width at count 7", pwm_o[2], 1);
    step(1, 0, 0, 0);
    chk(pwm_o[2] == 1'b0, "R7 new width low at count 8", pwm_o[2], 0);

    // R8: write channel 3 only; others keep their widths after wrap
    step(0, 1, 3, 900);
    wexp[3] = 900;
    run_to(0);
    run_to(600);
    chk(pwm_o == 4'b1001, "R8 only selected channel changed", pwm_o, 9);

    // R1: period length between rising edges of a width-0 channel
    step(0, 1, 0, 0);
    wexp[0] = 0;
    run_to(1023);
    step(1, 0, 0, 0);
    rises = 0; first_rise = 0; gap = 0;
    prev = pwm_o[0];
    for (int k = 0; k < 2100; k++) begin
      step(1, 0, 0, 0);
      if (pwm_o[0] && !prev) begin
        if (rises == 0) first_rise = k;
        else if (rises == 1) gap = k - first_rise;
        rises++;
      end
      prev = pwm_o[0];
    end
    chk(rises == 2, "R1 rises in window", rises, 2);
    chk(gap == 1024, "R1 period length", gap, 1024);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule